// File: doc/BRIEF.md
# Interleaved Memory Block-Fetch Controller

This controller refills one cache line at a time from a clocked memory bus backed by banks that each need a fixed number of bus cycles per access. The cache hands over a block address with a valid/ready handshake. The controller spends one bus cycle sending the address, waits out the bank latency, and then returns the line to the cache over a valid/ready response channel. Each response beat carries a word index, a per-lane valid mask and a flag on the final beat.

A parameter picks how memory is organised behind the bus, and each choice gives its own cycle-exact refill time. With a single one-word-wide bank, every word costs a full access followed by its own transfer. With a line-wide memory, one access is followed by a single transfer of the whole line. With one bank per word, all banks access in parallel and the words then stream out one per cycle. Bank contents come from a fixed function of the word address, so the line data is known for any block.

Only one refill is in flight at a time. A new request is taken only after the last beat of the current one has been accepted by the cache.

Top module: `memfetch_ctrl`

## Requirements
- R1: While the reset input is low, and for the first three clock edges after it rises, `req_ready` and `rsp_valid` are 0. From then on `req_ready` is 1 while idle.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. From the cycle after acceptance until the edge that accepts the last beat, `req_ready` is 0.
- R3: With `ORG`=0 (single one-word bank, 4 words, latency 15), the four beats are valid in cycles 17, 33, 49 and 65, counting the cycle right after the acceptance edge as cycle 1. The refill therefore lasts 65 cycles when the cache never stalls.
- R4: With `ORG`=1 (line-wide memory), one beat carrying all four words is valid in cycle 17. Its lane mask is 4'b1111, its index is 0 and its last flag is 1, so the refill lasts 17 cycles.
- R5: With `ORG`=2 (one bank per word), the four beats are valid in cycles 17, 18, 19 and 20, so the refill lasts 20 cycles.
- R6: Word j of block B lives at word address B*4+j and holds (addr*32'h9E3779B1) XOR 32'h5A5AC3C3, truncated to 32 bits. It appears in `rsp_data[j*32 +: 32]`. In a one-word beat, only the lane equal to `rsp_idx` is valid: the mask is 1<<idx and every other lane is zero. Beats come out in index order 0 to 3.
- R7: `rsp_last` is 1 on the final beat of a refill and 0 on every other beat.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, the beat is held unchanged. Every stalled cycle delays that beat and all later ones by exactly one cycle.
- R9: Toggling `req_valid` or `req_blk` while a refill is in flight has no effect on it. Its data stays that of the accepted block, and no extra beats follow its last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Refill request present |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_blk | input | BLK_W | Block address of the line to fetch |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Cache accepts the beat |
| rsp_data | output | WORDS*DATA_W | Line-wide data, lane j at bits j*DATA_W upward |
| rsp_lane_vld | output | WORDS | Per-lane valid mask of the current beat |
| rsp_idx | output | $clog2(WORDS) | Index of the first word in the beat |
| rsp_last | output | 1 | Final beat of the refill |

## Verification
A bank latency counter that is off by one moves the first beat away from cycle 17 at once, and in the one-bank organisation the error grows by one cycle on each later word until the total misses 65. A wrong beat pointer or bank select shows up on the very next beat as a wrong index, mask or data word, or as a last flag in the wrong place. A bank whose ready flag is lost or left set either stalls the stream so that the watchdog ends the run, or produces beats beyond the fourth, which the idle check after an interrupted refill catches. Backpressure runs hold the beat for several cycles and compare both its contents and the shifted timing.

// File: rtl/memfetch_pkg.sv
package memfetch_pkg;

  // memory organisation selector values
  localparam int ORG_NARROW     = 0;
  localparam int ORG_WIDE       = 1;
  localparam int ORG_INTERLEAVE = 2;

  typedef enum logic [1:0] {
    ST_BOOT = 2'd0,
    ST_IDLE = 2'd1,
    ST_ADDR = 2'd2,
    ST_RUN  = 2'd3
  } seq_st_e;

  // content model of the banks: a fixed scramble of the word address
  function automatic logic [31:0] fill_word(input logic [31:0] waddr);
    return (waddr * 32'h9E3779B1) ^ 32'h5A5AC3C3;
  endfunction

endpackage

// File: rtl/mf_bank.sv
module mf_bank
  import memfetch_pkg::*;
#(
  parameter int LANES   = 1,
  parameter int DATA_W  = 32,
  parameter int WADDR_W = 10,
  parameter int LAT     = 15
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      take,
  input  logic [WADDR_W-1:0]        base,
  output logic                      full,
  output logic [LANES*DATA_W-1:0]   data
);

  localparam int CNT_W = $clog2(LAT + 1);

  logic               busy_q, busy_n;
  logic               full_q, full_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [WADDR_W-1:0] addr_q, addr_n;
  logic               cap_en;
  logic [LANES*DATA_W-1:0] data_q, data_d;

  // word content for each lane of this bank
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [31:0] w;
    assign w = fill_word(32'(addr_q) + 32'(j));
    assign data_d[j*DATA_W +: DATA_W] = w[DATA_W-1:0];
  end

  always_comb begin
    busy_n = busy_q;
    full_n = full_q;
    cnt_n  = cnt_q;
    addr_n = addr_q;
    cap_en = 1'b0;
    if (take) full_n = 1'b0;
    if (start) begin
      busy_n = 1'b1;
      cnt_n  = CNT_W'(LAT - 1);
      addr_n = base;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_n = 1'b0;
        full_n = 1'b1;
        cap_en = 1'b1;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      full_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
    end else begin
      busy_q <= busy_n;
      full_q <= full_n;
      cnt_q  <= cnt_n;
      addr_q <= addr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (cap_en) begin
      data_q <= data_d;
    end
  end

  assign full = full_q;
  assign data = data_q;

  // R8
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_q && !take |=> full_q && $stable(data_q));

  // R3
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q && (!full_q || take));

endmodule

// File: rtl/mf_seq.sv
module mf_seq
  import memfetch_pkg::*;
#(
  parameter int ORG   = ORG_INTERLEAVE,
  parameter int WORDS = 4,
  parameter int BLK_W = 8,
  parameter int NB    = 4,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [BLK_W-1:0] req_blk,
  input  logic             rsp_ready,
  output logic             rsp_valid,
  output logic             rsp_last,
  input  logic [NB-1:0]    bank_full,
  output logic [NB-1:0]    bank_start,
  output logic [NB-1:0]    bank_take,
  output logic [IDX_W-1:0] beat,
  output logic [IDX_W-1:0] acc_word,
  output logic [BLK_W-1:0] blk
);

  localparam int BEATS = (ORG == ORG_WIDE) ? 1 : WORDS;

  seq_st_e          state_q, state_n;
  logic [IDX_W-1:0] beat_q, beat_n;
  logic [BLK_W-1:0] blk_q, blk_n;
  logic             cur_full;
  logic             hs;
  logic             last;

  if (ORG == ORG_INTERLEAVE) begin : g_sel_ilv
    assign cur_full  = bank_full[beat_q];
    assign bank_take = hs ? (NB'(1) << beat_q) : '0;
  end else begin : g_sel_one
    assign cur_full  = bank_full[0];
    assign bank_take = {NB{hs}};
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RUN) && cur_full;
  assign hs        = rsp_valid && rsp_ready;
  assign last      = (beat_q == IDX_W'(BEATS - 1));
  assign rsp_last  = rsp_valid && last;

  always_comb begin
    state_n    = state_q;
    beat_n     = beat_q;
    blk_n      = blk_q;
    bank_start = '0;
    acc_word   = '0;
    unique case (state_q)
      ST_BOOT: state_n = ST_IDLE;
      ST_IDLE: begin
        if (req_valid) begin
          blk_n   = req_blk;
          beat_n  = '0;
          state_n = ST_ADDR;
        end
      end
      ST_ADDR: begin
        bank_start = '1;
        state_n    = ST_RUN;
      end
      ST_RUN: begin
        if (hs) begin
          if (last) begin
            state_n = ST_IDLE;
          end else begin
            beat_n   = beat_q + 1'b1;
            acc_word = beat_q + 1'b1;
            if (ORG == ORG_NARROW) bank_start[0] = 1'b1;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_BOOT;
      beat_q  <= '0;
      blk_q   <= '0;
    end else begin
      state_q <= state_n;
      beat_q  <= beat_n;
      blk_q   <= blk_n;
    end
  end

  assign beat = beat_q;
  assign blk  = blk_q;

  // R2
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid && (bank_full == '0));

  // R9
  blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready && state_q != ST_BOOT |=> $stable(blk_q));

endmodule

// File: rtl/mf_lanes.sv
module mf_lanes
  import memfetch_pkg::*;
#(
  parameter int ORG    = ORG_INTERLEAVE,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int NB     = 4,
  parameter int BANK_W = 32,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic [NB*BANK_W-1:0]   bank_data,
  input  logic [IDX_W-1:0]       beat,
  input  logic                   valid,
  output logic [WORDS*DATA_W-1:0] data,
  output logic [WORDS-1:0]       lane_vld,
  output logic [IDX_W-1:0]       idx
);

  assign idx = beat;

  if (ORG == ORG_WIDE) begin : g_wide
    assign data     = valid ? bank_data : '0;
    assign lane_vld = {WORDS{valid}};
  end else begin : g_word
    logic [DATA_W-1:0] word;
    if (ORG == ORG_INTERLEAVE) begin : g_pick
      assign word = bank_data[beat*DATA_W +: DATA_W];
    end else begin : g_only
      assign word = bank_data[DATA_W-1:0];
    end
    for (genvar j = 0; j < WORDS; j++) begin : g_lane
      logic hit;
      assign hit = valid && (beat == IDX_W'(j));
      assign data[j*DATA_W +: DATA_W] = hit ? word : '0;
      assign lane_vld[j] = hit;
    end
  end

endmodule

// File: rtl/memfetch_ctrl.sv
module memfetch_ctrl
  import memfetch_pkg::*;
#(
  parameter int ORG    = ORG_INTERLEAVE,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int BLK_W  = 8,
  parameter int LAT    = 15,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [BLK_W-1:0]        req_blk,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [WORDS*DATA_W-1:0] rsp_data,
  output logic [WORDS-1:0]        rsp_lane_vld,
  output logic [IDX_W-1:0]        rsp_idx,
  output logic                    rsp_last
);

  localparam int NB       = (ORG == ORG_INTERLEAVE) ? WORDS : 1;
  localparam int LANES    = (ORG == ORG_WIDE) ? WORDS : 1;
  localparam int BANK_W   = LANES * DATA_W;
  localparam int WADDR_W  = BLK_W + IDX_W;
  localparam int BEATS    = (ORG == ORG_WIDE) ? 1 : WORDS;
  localparam int ACCESSES = (ORG == ORG_NARROW) ? WORDS : 1;
  localparam int PENALTY  = 1 + ACCESSES * LAT + BEATS;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  logic [NB-1:0]        bank_full, bank_start, bank_take;
  logic [NB*BANK_W-1:0] bank_data;
  logic [IDX_W-1:0]     beat, acc_word;
  logic [BLK_W-1:0]     blk;

  mf_seq #(
    .ORG(ORG), .WORDS(WORDS), .BLK_W(BLK_W), .NB(NB)
  ) u_seq (
    .clk(clk), .rst_n(rst_s_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_blk(req_blk),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_last(rsp_last),
    .bank_full(bank_full), .bank_start(bank_start), .bank_take(bank_take),
    .beat(beat), .acc_word(acc_word), .blk(blk)
  );

  for (genvar k = 0; k < NB; k++) begin : g_bank
    logic [WADDR_W-1:0] base;
    assign base = {blk, acc_word + IDX_W'(k)};
    mf_bank #(
      .LANES(LANES), .DATA_W(DATA_W), .WADDR_W(WADDR_W), .LAT(LAT)
    ) u_bank (
      .clk(clk), .rst_n(rst_s_n),
      .start(bank_start[k]), .take(bank_take[k]), .base(base),
      .full(bank_full[k]), .data(bank_data[k*BANK_W +: BANK_W])
    );
  end

  mf_lanes #(
    .ORG(ORG), .WORDS(WORDS), .DATA_W(DATA_W), .NB(NB), .BANK_W(BANK_W)
  ) u_lanes (
    .bank_data(bank_data), .beat(beat), .valid(rsp_valid),
    .data(rsp_data), .lane_vld(rsp_lane_vld), .idx(rsp_idx)
  );

  // refill-length monitor for the penalty check
  logic [15:0] cyc_q;
  logic        stall_q;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cyc_q   <= '0;
      stall_q <= 1'b0;
    end else if (req_valid && req_ready) begin
      cyc_q   <= 16'd1;
      stall_q <= 1'b0;
    end else if (!req_ready) begin
      cyc_q   <= cyc_q + 1'b1;
      stall_q <= stall_q || (rsp_valid && !rsp_ready);
    end
  end

  // R3 R4 R5
  penalty_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    rsp_last && rsp_ready && !stall_q |-> cyc_q == 16'(PENALTY));

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_idx));

  // R7
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    rsp_last |-> rsp_valid && rsp_lane_vld[WORDS-1]);

  // R1
  boot_quiet_chk: assert property (@(posedge clk)
    !rst_s_n |-> !req_ready && !rsp_valid);

endmodule

// File: tb/sim_memfetch_ctrl.sv
`timescale 1ns/1ps
module sim_memfetch_ctrl;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic         rv [3];
  logic         rr [3];
  logic [7:0]   blk;
  logic         rq [3];
  logic         vo [3];
  logic [127:0] rd [3];
  logic [3:0]   lv [3];
  logic [1:0]   ix [3];
  logic         la [3];

  memfetch_ctrl #(.ORG(0)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(rv[0]), .req_ready(rq[0]), .req_blk(blk),
    .rsp_valid(vo[0]), .rsp_ready(rr[0]), .rsp_data(rd[0]), .rsp_lane_vld(lv[0]),
    .rsp_idx(ix[0]), .rsp_last(la[0]));
  memfetch_ctrl #(.ORG(1)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(rv[1]), .req_ready(rq[1]), .req_blk(blk),
    .rsp_valid(vo[1]), .rsp_ready(rr[1]), .rsp_data(rd[1]), .rsp_lane_vld(lv[1]),
    .rsp_idx(ix[1]), .rsp_last(la[1]));
  memfetch_ctrl #(.ORG(2)) u2 (
    .clk(clk), .rst_n(rst_n), .req_valid(rv[2]), .req_ready(rq[2]), .req_blk(blk),
    .rsp_valid(vo[2]), .rsp_ready(rr[2]), .rsp_data(rd[2]), .rsp_lane_vld(lv[2]),
    .rsp_idx(ix[2]), .rsp_last(la[2]));

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string what, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [7:0] b, input int j);
    logic [31:0] a;
    a = 32'(b) * 32'd4 + 32'(j);
    return (a * 32'h9E3779B1) ^ 32'h5A5AC3C3;
  endfunction

  // one refill on DUT d; stall_len cycles of backpressure on the first beat
  task automatic do_refill(input int d, input logic [7:0] b, input int stall_len,
                           input bit intr, input string tag);
    int cyc, beat, nbeats, gap, pen, scnt, exp_cyc;
    bit done;
    logic [127:0] exp_d;
    logic [3:0]   exp_m;
    nbeats = (d == 1) ? 1 : 4;
    gap    = (d == 0) ? 16 : 1;
    pen    = (d == 0) ? 65 : ((d == 1) ? 17 : 20);
    @(negedge clk);
    while (!rq[d]) @(negedge clk);
    blk   = b;
    rv[d] = 1'b1;
    rr[d] = (stall_len == 0);
    @(posedge clk);
    cyc = 0; beat = 0; scnt = 0; done = 1'b0;
    while (!done && cyc < 300) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        rv[d] = intr;
        if (intr) blk = ~b;
        check(rq[d] == 1'b0, {tag, " R2 req_ready low after accept"}, 128'(rq[d]), 128'd0);
      end
      if (cyc == 10) rv[d] = 1'b0;
      if (vo[d]) begin
        exp_d = '0;
        if (d == 1) begin
          exp_m = 4'hF;
          for (int j = 0; j < 4; j++) exp_d[j*32 +: 32] = mem_word(b, j);
        end else begin
          exp_m = 4'(1 << beat);
          exp_d[beat*32 +: 32] = mem_word(b, beat);
        end
        if (!rr[d]) begin
          if (scnt == stall_len) rr[d] = 1'b1;
          else scnt++;
        end
        if (!rr[d]) begin
          check(rd[d] == exp_d, {tag, " R8 held data during stall"}, rd[d], exp_d);
        end else begin
          exp_cyc = 17 + beat * gap + stall_len;
          check(cyc == exp_cyc, {tag, " beat cycle"}, 128'(cyc), 128'(exp_cyc));
          check(rd[d] == exp_d, {tag, " R6 beat data"}, rd[d], exp_d);
          check(lv[d] == exp_m, {tag, " R6 lane mask"}, 128'(lv[d]), 128'(exp_m));
          check(ix[d] == 2'((d == 1) ? 0 : beat), {tag, " R6 index"}, 128'(ix[d]),
                128'((d == 1) ? 0 : beat));
          check(la[d] == (beat == nbeats - 1), {tag, " R7 last flag"}, 128'(la[d]),
                128'(beat == nbeats - 1));
          check(rq[d] == 1'b0, {tag, " R2 busy during beat"}, 128'(rq[d]), 128'd0);
          if (beat == nbeats - 1) begin
            check(cyc == pen + stall_len, {tag, " total refill cycles"}, 128'(cyc),
                  128'(pen + stall_len));
            done = 1'b1;
          end else begin
            beat++;
          end
        end
      end
    end
    check(done, {tag, " refill completed"}, 128'(done), 128'd1);
    rr[d] = 1'b1;
    if (intr) begin
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        check(vo[d] == 1'b0, {tag, " R9 no beat after last"}, 128'(vo[d]), 128'd0);
      end
      check(rq[d] == 1'b1, {tag, " R9 idle again"}, 128'(rq[d]), 128'd1);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    for (int d = 0; d < 3; d++) begin rv[d] = 1'b0; rr[d] = 1'b1; end
    blk = '0;
    repeat (3) @(negedge clk);
    for (int d = 0; d < 3; d++) begin
      check(rq[d] == 1'b0, "R1 ready low in reset", 128'(rq[d]), 128'd0);
      check(vo[d] == 1'b0, "R1 no beat in reset", 128'(vo[d]), 128'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check(rq[2] == 1'b0, "R1 ready low just after release", 128'(rq[2]), 128'd0);
    repeat (3) @(negedge clk);
    for (int d = 0; d < 3; d++)
      check(rq[d] == 1'b1, "R1 ready high when idle", 128'(rq[d]), 128'd1);
  endtask

  task automatic t_narrow();     do_refill(0, 8'h2C, 0, 1'b0, "R3 narrow");       endtask
  task automatic t_wide();       do_refill(1, 8'h81, 0, 1'b0, "R4 wide");         endtask
  task automatic t_interleave(); do_refill(2, 8'h13, 0, 1'b0, "R5 interleaved");  endtask
  task automatic t_stall();
    do_refill(2, 8'h40, 3, 1'b0, "R8 interleaved stall");
    do_refill(0, 8'h07, 2, 1'b0, "R8 narrow stall");
    do_refill(1, 8'h5E, 4, 1'b0, "R8 wide stall");
  endtask
  task automatic t_busy_req();
    do_refill(0, 8'h9A, 0, 1'b1, "R9 narrow busy request");
    do_refill(2, 8'h66, 0, 1'b1, "R9 interleaved busy request");
  endtask
  task automatic t_edges();
    do_refill(2, 8'hFF, 0, 1'b0, "R6 top block");
    do_refill(2, 8'h00, 0, 1'b0, "R6 block zero");
    do_refill(1, 8'hFF, 0, 1'b0, "R6 wide top block");
  endtask

  initial begin
    t_reset();
    t_narrow();
    t_wide();
    t_interleave();
    t_stall();
    t_busy_req();
    t_edges();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule